// File: doc/BRIEF.md
# Triplex LCD Multiplex Sequencer

This block sequences a one-third-duty multiplexed liquid crystal display with three backplanes and twelve segment pins, which give 36 dots. A slot timer counts timebase ticks. Each frame is split into six equal slots, and each backplane is active once with positive polarity and once with negative polarity. Every pin gets a two-bit level code: high rail, low rail, lower intermediate or upper intermediate. An analog stage outside this block turns each code into a voltage. The dots come from a 36-bit latched data word that a separate loader fills.

For cascaded displays, a mode input chooses the timebase and sets the role of the two outer backplane pins. A stand-alone unit drives all three backplanes. A master sends its timebase out on the C pin. A slave runs from the partner's tick and gives up the A pin as the oscillator input. The master pulses a frame mark at the end of each frame. A slave with synchronisation enabled restarts its frame on that mark, so both halves of an eight-digit display scan in phase.

Top module: `lcd_triplex_seq`

## Requirements
- R1: While `rst_n` is low, the slot counter and the tick counter are zero. The first slot after reset is backplane A, positive polarity.
- R2: A slot lasts SLOT_TICKS selected ticks (default 32), so a frame lasts 192 ticks. Cycles without a selected tick leave the timing state unchanged.
- R3: Slots run in the order A+, B+, C+, A-, B-, C-. The active backplane is at 2'b11 in a positive slot and at 2'b00 in a negative slot. The inactive backplanes are at 2'b01 in a positive slot and at 2'b10 in a negative slot.
- R4: The code of a segment pin depends on the polarity of the slot and on the dot at that pin and the active backplane. In a positive slot, a pin whose dot is on is at 2'b00 and a pin whose dot is off is at 2'b10. In a negative slot, an on dot gives 2'b11 and an off dot gives 2'b01.
- R5: The dot word is laid out as follows. Bits 8n..8n+7 belong to digit n, in the order a, b, c, d, e, f, g, h starting from bit 8n. Bit 32+n is the special mark of digit n. Segment pin 3n is pin X of digit n, pin 3n+1 is Y and pin 3n+2 is Z. Pin p occupies `seg_lvl[2p+1:2p]`. The dots are wired as follows:
  - pin X shows b under A, c under B and h under C;
  - pin Y shows a under A, g under B and d under C;
  - pin Z shows f under A, e under B and the special mark under C.
- R6: `mode` selects the role: 2'b11 is slave, 2'b01 is stand-alone, 2'b00 is master and 2'b10 is spare. A slave counts `ext_tick` and ignores `osc_tick`. Every other mode counts `osc_tick` and ignores `ext_tick`.
- R7: In slave and spare modes, pin A is an input: `bpa_drv` is 0 and `bpa_lvl` is 2'b00. In master and spare modes, pin C carries the timebase: `bpc_osc` is 1 and `bpc_lvl` is 2'b11 in a cycle with `osc_tick` and 2'b00 in any other cycle.
- R8: When `sync_en` and `sync_in` are both high, the next clock edge resets both counters to slot 0, tick 0. This restart takes priority over a tick. When `sync_en` is low, `sync_in` has no effect.
- R9: `frame_mark` is high exactly in a cycle with a selected tick while the timer is in the last tick of slot 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Local timebase tick enable |
| ext_tick | input | 1 | Timebase tick from a master unit |
| mode | input | 2 | Role select (R6 encoding) |
| sync_en | input | 1 | Enables frame restart from partner |
| sync_in | input | 1 | Partner frame mark |
| dots | input | 36 | Latched dot data (R5 layout) |
| bpa_lvl | output | 2 | Backplane A level code |
| bpb_lvl | output | 2 | Backplane B level code |
| bpc_lvl | output | 2 | Backplane C level code, or timebase copy |
| bpa_drv | output | 1 | Pin A drives a backplane |
| bpc_osc | output | 1 | Pin C carries the timebase |
| seg_lvl | output | 24 | Twelve segment level codes, 2 bits each |
| frame_mark | output | 1 | End-of-frame pulse |

## Verification
A fixed dot word held for two whole frames shows the slot order and both polarities. A dot word that changes every few cycles tells apart the crossings of all 36 dots, so a swapped bit or pin in the scrambled map shows up. Sparse ticks separate counting by ticks from counting by cycles. Slave runs with a toggling `osc_tick` show which timebase is in use, and the master and spare runs show the pin roles. Restart pulses given in the middle of a frame, with the enable set and then clear, tell a real restart from the normal wrap.

// File: rtl/lcdmux_pkg.sv
package lcdmux_pkg;

    typedef enum logic [1:0] {
        LV_LOW   = 2'b00,
        LV_MIDLO = 2'b01,
        LV_MIDHI = 2'b10,
        LV_HIGH  = 2'b11
    } lvl_e;

    typedef enum logic [1:0] {
        MD_MASTER = 2'b00,
        MD_ALONE  = 2'b01,
        MD_SPARE  = 2'b10,
        MD_SLAVE  = 2'b11
    } mode_e;

    localparam int NUM_SLOTS = 6;
    localparam int SLOT_W    = 3;
    localparam int NUM_PLANES = 3;

    // backplane index (0=A,1=B,2=C) active in a slot
    function automatic logic [1:0] plane_of(input logic [SLOT_W-1:0] s);
        logic [SLOT_W-1:0] t;
        t = (s >= 3'd3) ? (s - 3'd3) : s;
        return t[1:0];
    endfunction

    function automatic logic positive(input logic [SLOT_W-1:0] s);
        return (s < 3'd3);
    endfunction

    function automatic lvl_e plane_level(input logic active, input logic pos);
        if (active) return pos ? LV_HIGH : LV_LOW;
        return pos ? LV_MIDLO : LV_MIDHI;
    endfunction

    function automatic lvl_e seg_level(input logic on, input logic pos);
        if (on) return pos ? LV_LOW : LV_HIGH;
        return pos ? LV_MIDHI : LV_MIDLO;
    endfunction

endpackage

// File: rtl/lcdmux_timer.sv
module lcdmux_timer
    import lcdmux_pkg::*;
#(
    parameter int SLOT_TICKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    output logic [SLOT_W-1:0] slot,
    output logic              frame_mark
);
    localparam int CW = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
    localparam logic [CW-1:0] LAST_TICK = CW'(SLOT_TICKS - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [SLOT_W-1:0] slot;
    } tmr_t;

    tmr_t st_d, st_q;
    logic end_slot;

    always_comb begin
        st_d     = st_q;
        end_slot = (st_q.cnt == LAST_TICK);
        if (restart) begin
            st_d = '0;
        end else if (tick) begin
            if (end_slot) begin
                st_d.cnt  = '0;
                st_d.slot = (st_q.slot == LAST_SLOT) ? '0 : st_q.slot + 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot       = st_q.slot;
    assign frame_mark = tick && end_slot && (st_q.slot == LAST_SLOT);

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot <= LAST_SLOT);                                              // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(st_q));                               // R2
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_mark && !restart) |=> (st_q.slot == '0 && st_q.cnt == '0));   // R9
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q == '0));                                            // R8

endmodule

// File: rtl/lcdmux_segdrv.sv
module lcdmux_segdrv
    import lcdmux_pkg::*;
#(
    parameter int NUM_DIGITS = 4
) (
    input  logic [9*NUM_DIGITS-1:0] dots,
    input  logic [SLOT_W-1:0]       slot,
    output logic [6*NUM_DIGITS-1:0] seg_lvl
);
    logic [1:0] plane;
    logic       pos;

    assign plane = plane_of(slot);
    assign pos   = positive(slot);

    for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
        logic [7:0] byte_q;
        logic       mark;
        logic       x_on, y_on, z_on;

        assign byte_q = dots[8*d +: 8];
        assign mark   = dots[8*NUM_DIGITS + d];

        always_comb begin
            unique case (plane)
                2'd0: begin x_on = byte_q[1]; y_on = byte_q[0]; z_on = byte_q[5]; end
                2'd1: begin x_on = byte_q[2]; y_on = byte_q[6]; z_on = byte_q[4]; end
                default: begin x_on = byte_q[7]; y_on = byte_q[3]; z_on = mark; end
            endcase
        end

        assign seg_lvl[6*d +: 2]     = seg_level(x_on, pos);
        assign seg_lvl[6*d + 2 +: 2] = seg_level(y_on, pos);
        assign seg_lvl[6*d + 4 +: 2] = seg_level(z_on, pos);
    end

endmodule

// File: rtl/lcdmux_pinrole.sv
module lcdmux_pinrole
    import lcdmux_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic              osc_tick,
    input  logic              ext_tick,
    input  logic [SLOT_W-1:0] slot,
    output logic              tick_sel,
    output logic [1:0]        bpa_lvl,
    output logic [1:0]        bpb_lvl,
    output logic [1:0]        bpc_lvl,
    output logic              bpa_drv,
    output logic              bpc_osc
);
    mode_e      md;
    logic [1:0] plane;
    logic       pos;
    logic [NUM_PLANES-1:0][1:0] lvl;

    assign md    = mode_e'(mode);
    assign plane = plane_of(slot);
    assign pos   = positive(slot);

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        assign lvl[p] = plane_level(plane == 2'(p), pos);
    end

    always_comb begin
        tick_sel = (md == MD_SLAVE) ? ext_tick : osc_tick;
        bpa_drv  = (md == MD_ALONE) || (md == MD_MASTER);
        bpc_osc  = (md == MD_MASTER) || (md == MD_SPARE);
        bpa_lvl  = bpa_drv ? lvl[0] : LV_LOW;
        bpb_lvl  = lvl[1];
        bpc_lvl  = bpc_osc ? (osc_tick ? LV_HIGH : LV_LOW) : lvl[2];
    end

endmodule

// File: rtl/lcd_triplex_seq.sv
module lcd_triplex_seq
    import lcdmux_pkg::*;
#(
    parameter int SLOT_TICKS = 32,
    parameter int NUM_DIGITS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    osc_tick,
    input  logic                    ext_tick,
    input  logic [1:0]              mode,
    input  logic                    sync_en,
    input  logic                    sync_in,
    input  logic [9*NUM_DIGITS-1:0] dots,
    output logic [1:0]              bpa_lvl,
    output logic [1:0]              bpb_lvl,
    output logic [1:0]              bpc_lvl,
    output logic                    bpa_drv,
    output logic                    bpc_osc,
    output logic [6*NUM_DIGITS-1:0] seg_lvl,
    output logic                    frame_mark
);
    logic [SLOT_W-1:0] slot;
    logic              tick_sel;
    logic              restart;

    assign restart = sync_en && sync_in;

    lcdmux_pinrole i_role (
        .mode     (mode),
        .osc_tick (osc_tick),
        .ext_tick (ext_tick),
        .slot     (slot),
        .tick_sel (tick_sel),
        .bpa_lvl  (bpa_lvl),
        .bpb_lvl  (bpb_lvl),
        .bpc_lvl  (bpc_lvl),
        .bpa_drv  (bpa_drv),
        .bpc_osc  (bpc_osc)
    );

    lcdmux_timer #(.SLOT_TICKS(SLOT_TICKS)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_sel),
        .restart    (restart),
        .slot       (slot),
        .frame_mark (frame_mark)
    );

    lcdmux_segdrv #(.NUM_DIGITS(NUM_DIGITS)) i_seg (
        .dots    (dots),
        .slot    (slot),
        .seg_lvl (seg_lvl)
    );

    logic ra, rb, rc;
    assign ra = (bpa_lvl == LV_HIGH) || (bpa_lvl == LV_LOW);
    assign rb = (bpb_lvl == LV_HIGH) || (bpb_lvl == LV_LOW);
    assign rc = (bpc_lvl == LV_HIGH) || (bpc_lvl == LV_LOW);

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_ALONE) |-> ($countones({ra, rb, rc}) == 1));              // R3
    AST_PIN_A_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |-> (!bpa_drv && bpa_lvl == LV_LOW));                         // R7
    AST_SLAVE_TIMEBASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_SLAVE && !ext_tick && !restart) |=> $stable(slot));       // R6
    AST_MARK_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        frame_mark |-> (slot == 3'd5));                                       // R9

endmodule

// File: tb/test_lcd_triplex_seq.sv
module test_lcd_triplex_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TICKS = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic osc_tick, ext_tick, sync_en, sync_in;
    logic [1:0]  mode;
    logic [35:0] dots;
    logic [1:0]  bpa_lvl, bpb_lvl, bpc_lvl;
    logic        bpa_drv, bpc_osc, frame_mark;
    logic [23:0] seg_lvl;

    // pending stimulus, applied at the next falling edge
    logic        n_rst_n = 1'b0, n_osc = 1'b0, n_ext = 1'b0, n_sen = 1'b0, n_sin = 1'b0;
    logic [1:0]  n_mode = 2'b01;
    logic [35:0] n_dots = '0;

    int m_cnt, m_slot;
    int n_checks = 0, n_fails = 0, cycles = 0;
    bit done = 0;
    string stage = "R1 reset";

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_triplex_seq i_lcd_triplex_seq (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ext_tick(ext_tick),
        .mode(mode), .sync_en(sync_en), .sync_in(sync_in), .dots(dots),
        .bpa_lvl(bpa_lvl), .bpb_lvl(bpb_lvl), .bpc_lvl(bpc_lvl),
        .bpa_drv(bpa_drv), .bpc_osc(bpc_osc), .seg_lvl(seg_lvl),
        .frame_mark(frame_mark)
    );

    // data bit shown by segment pin p under backplane b (R5)
    function automatic int dot_bit(int p, int b);
        int dg = p / 3;
        case ((p % 3) * 3 + b)
            0: return 8*dg + 1;
            1: return 8*dg + 2;
            2: return 8*dg + 7;
            3: return 8*dg + 0;
            4: return 8*dg + 6;
            5: return 8*dg + 3;
            6: return 8*dg + 5;
            7: return 8*dg + 4;
            default: return 32 + dg;
        endcase
    endfunction

    function automatic logic [1:0] exp_plane(int idx, int s);
        bit act = ((s % 3) == idx);
        if (s < 3) return act ? 2'b11 : 2'b01;
        return act ? 2'b00 : 2'b10;
    endfunction

    task automatic check(string tag, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fails++;
            $display("FAIL %s [%s] cyc %0d: actual %0h expected %0h", tag, stage, cycles, act, expv);
        end
    endtask

    task automatic cyc();
        bit tk;
        logic [23:0] es;
        @(negedge clk);
        rst_n = n_rst_n; osc_tick = n_osc; ext_tick = n_ext;
        sync_en = n_sen; sync_in = n_sin; mode = n_mode; dots = n_dots;
        if (!rst_n) begin m_cnt = 0; m_slot = 0; end
        #1;
        tk = (mode == 2'b11) ? ext_tick : osc_tick;
        // R3 backplanes, R7 pin roles
        check("R3 bpb", bpb_lvl, exp_plane(1, m_slot));
        if (mode[1]) check("R7 bpa input", {bpa_drv, bpa_lvl}, 0);
        else         check("R3 bpa", {bpa_drv, bpa_lvl}, {1'b1, exp_plane(0, m_slot)});
        if (!mode[0]) check("R7 bpc timebase", {bpc_osc, bpc_lvl}, {1'b1, (osc_tick ? 2'b11 : 2'b00)});
        else          check("R3 bpc", {bpc_osc, bpc_lvl}, {1'b0, exp_plane(2, m_slot)});
        // R4 R5 segment codes
        for (int p = 0; p < 12; p++) begin
            bit on = dots[dot_bit(p, m_slot % 3)];
            if (m_slot < 3) es[2*p +: 2] = on ? 2'b00 : 2'b10;
            else            es[2*p +: 2] = on ? 2'b11 : 2'b01;
        end
        check("R4 R5 seg", seg_lvl, es);
        check("R9 mark", frame_mark, (rst_n && tk && m_slot == 5 && m_cnt == TICKS-1) ? 1 : 0);
        // advance model to the coming rising edge
        if (rst_n) begin
            if (sync_en && sync_in) begin m_cnt = 0; m_slot = 0; end
            else if (tk) begin
                if (m_cnt == TICKS-1) begin m_cnt = 0; m_slot = (m_slot + 1) % 6; end
                else m_cnt++;
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_fails++;
            $display("FAIL watchdog: actual hang expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [35:0] lf = 36'h9_A5C3_1E77;
        rst_n = 0; osc_tick = 0; ext_tick = 0; sync_en = 0; sync_in = 0; mode = 2'b01; dots = '0;
        n_dots = 36'h5_3C96_A18F; n_osc = 1;
        repeat (4) cyc();
        check("R1 reset slot", {bpa_lvl, bpb_lvl, bpc_lvl}, 6'b11_01_01);
        n_rst_n = 1;

        stage = "R3 R4 R5 fixed dots";
        repeat (400) cyc();
        stage = "R5 changing dots";
        for (int i = 0; i < 600; i++) begin
            if (i % 5 == 0) begin lf = {lf[34:0], lf[35] ^ lf[24]}; n_dots = lf; end
            cyc();
        end

        stage = "R2 sparse ticks";
        for (int i = 0; i < 700; i++) begin n_osc = (i % 3 == 0); cyc(); end

        stage = "R6 slave ext timebase";
        n_mode = 2'b11;
        for (int i = 0; i < 500; i++) begin n_osc = (i % 4 != 1); n_ext = (i % 2 == 0); cyc(); end

        stage = "R7 master";
        n_mode = 2'b00;
        for (int i = 0; i < 300; i++) begin n_osc = (i % 3 != 2); n_ext = 1; cyc(); end
        stage = "R7 spare";
        n_mode = 2'b10;
        for (int i = 0; i < 300; i++) begin n_osc = (i % 2 == 1); n_ext = 0; cyc(); end

        stage = "R8 sync restart";
        n_mode = 2'b01; n_osc = 1; n_sen = 1;
        for (int i = 0; i < 600; i++) begin n_sin = (i % 150 == 77); cyc(); end
        stage = "R8 sync disabled";
        n_sen = 0;
        for (int i = 0; i < 400; i++) begin n_sin = (i % 100 == 33); cyc(); end
        n_sin = 0;
        cyc();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule